// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the master side of a single open-drain data line that has an external pull-up. It produces the bus reset pulse and watches for a device's presence response. It also produces three kinds of bit slot: write-0, write-1 and read. The block never drives the line high. `line_oe` pulls the line low when set, and `line_in` is the level sensed on the pad.

A host asks for one operation at a time. It pulses `start` with an operation code, and for writes it also supplies a data bit. `busy` is high for the whole operation, and `done` marks its end. The results stay on `rd_bit` and `presence` until a later operation of the same kind replaces them. The block divides the system clock into a 1 µs tick, and every protocol time is counted in these ticks. The parameter `CLK_HZ` sets the divider.

Top module: `sw_bus_master`

## Requirements
- R1: After reset, `busy`, `done`, `line_oe`, `rd_bit` and `presence` are all 0.
- R2: `op` encodes the operation as 0 = bus reset, 1 = write bit, 2 = read bit. When the block is idle and `start` is high on a clock edge with one of these codes, the operation is accepted and `busy` is 1 from the next cycle. Code 3 is ignored: `busy` and `line_oe` stay 0.
- R3: While `busy` is 1, `start` has no effect on the running operation or on its results.
- R4: A write with `wr_bit` = 1 holds `line_oe` high for 6 µs from acceptance and then releases the line. The operation ends 61 µs after acceptance.
- R5: A write with `wr_bit` = 0 holds `line_oe` high for 60 µs and ends 61 µs after acceptance.
- R6: A read holds `line_oe` high for 6 µs and samples the synchronized line at 15 µs. `rd_bit` takes the sampled level. The operation ends at 61 µs. `rd_bit` changes only when a read samples.
- R7: A bus reset holds `line_oe` high for 480 µs and then keeps the line released for a further 480 µs. The operation ends 960 µs after acceptance. The low time is clamped to at most 900 µs whatever the parameter says.
- R8: A bus reset clears `presence` when it is accepted. `presence` is set if the line is seen low on a tick between 15 µs and 120 µs after the release. Reads and writes leave `presence` unchanged.
- R9: `done` is high for exactly one clock, in the first cycle in which `busy` is 0 again.
- R10: One µs is CLK_HZ/1,000,000 clocks. The tick counter restarts at acceptance, so every edge above falls on an exact multiple of that count after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Operation request strobe |
| op | input | 2 | Operation code: 0 bus reset, 1 write, 2 read |
| wr_bit | input | 1 | Bit sent by a write operation |
| line_in | input | 1 | Sensed level of the bus line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |
| rd_bit | output | 1 | Bit captured by the last read |
| presence | output | 1 | Presence seen during the last bus reset |
| line_oe | output | 1 | Pulls the line low when 1 |

## Verification
`busy` and `line_oe` respond in the cycle after the accepting edge. `line_oe` falls exactly (low time × divider) clocks after acceptance. `done` appears exactly (61 or 960 µs × divider) clocks after acceptance. `rd_bit` and `presence` are final by the `done` cycle. The bench keeps a behavioural count of clocks since acceptance and compares `busy`, `done` and `line_oe` with it at every falling edge. It then reads `rd_bit` and `presence` in the `done` cycle. Simulated device responses are placed clear of the two-flop synchronizer delay, so each outcome is fixed.

// File: rtl/sw_bus_pkg.sv
package sw_bus_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } sw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RST  = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } sw_state_e;

endpackage

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
  parameter int unsigned DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = run;
    end else begin : g_count
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);

      logic [DW-1:0] cnt_q;
      logic [DW-1:0] cnt_d;

      assign tick = run && (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '1;
        end else begin
          sh_q <= d;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '1;
        end else begin
          sh_q <= {sh_q[STAGES-2:0], d};
        end
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/sw_slot_engine.sv
module sw_slot_engine
  import sw_bus_pkg::*;
#(
  parameter int unsigned RST_LOW_US   = 480,
  parameter int unsigned RST_CAP_US   = 900,
  parameter int unsigned RST_HIGH_US  = 480,
  parameter int unsigned PD_START_US  = 15,
  parameter int unsigned PD_END_US    = 120,
  parameter int unsigned W0_LOW_US    = 60,
  parameter int unsigned W1_LOW_US    = 6,
  parameter int unsigned RD_LOW_US    = 6,
  parameter int unsigned RD_SAMPLE_US = 15,
  parameter int unsigned SLOT_US      = 60,
  parameter int unsigned REC_US       = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       wr_bit,
  input  logic       line_s,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       presence,
  output logic       line_oe
);

  localparam int unsigned RST_LOW_EFF = (RST_LOW_US > RST_CAP_US) ? RST_CAP_US : RST_LOW_US;
  localparam int unsigned RST_END     = RST_LOW_EFF + RST_HIGH_US;
  localparam int unsigned SLOT_END    = SLOT_US + REC_US;
  localparam int unsigned MAX_END     = (RST_END > SLOT_END) ? RST_END : SLOT_END;
  localparam int unsigned CNT_W       = $clog2(MAX_END + 1);

  localparam logic [CNT_W-1:0] C_RST_LOW   = CNT_W'(RST_LOW_EFF);
  localparam logic [CNT_W-1:0] C_RST_LAST  = CNT_W'(RST_END - 1);
  localparam logic [CNT_W-1:0] C_SLOT_LAST = CNT_W'(SLOT_END - 1);
  localparam logic [CNT_W-1:0] C_W0        = CNT_W'(W0_LOW_US);
  localparam logic [CNT_W-1:0] C_W1        = CNT_W'(W1_LOW_US);
  localparam logic [CNT_W-1:0] C_RD_LOW    = CNT_W'(RD_LOW_US);
  localparam logic [CNT_W-1:0] C_RD_SMP    = CNT_W'(RD_SAMPLE_US - 1);
  localparam logic [CNT_W-1:0] C_PD_LO     = CNT_W'(RST_LOW_EFF + PD_START_US - 1);
  localparam logic [CNT_W-1:0] C_PD_HI     = CNT_W'(RST_LOW_EFF + PD_END_US - 1);

  sw_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wbit_q, wbit_d;
  logic             rbit_q, rbit_d;
  logic             pres_q, pres_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] last_c;
  sw_op_e           op_c;

  assign op_c   = sw_op_e'(op);
  assign last_c = (state_q == ST_RST) ? C_RST_LAST : C_SLOT_LAST;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wbit_d  = wbit_q;
    rbit_d  = rbit_q;
    pres_d  = pres_q;
    done_d  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start && (op_c != OP_NONE)) begin
        cnt_d  = '0;
        wbit_d = wr_bit;
        unique case (op_c)
          OP_RESET: begin
            state_d = ST_RST;
            pres_d  = 1'b0;
          end
          OP_WRITE: state_d = ST_WR;
          default:  state_d = ST_RD;
        endcase
      end
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if ((state_q == ST_RD) && (cnt_q == C_RD_SMP)) begin
        rbit_d = line_s;
      end
      if ((state_q == ST_RST) && (cnt_q >= C_PD_LO) && (cnt_q < C_PD_HI) && !line_s) begin
        pres_d = 1'b1;
      end
      if (cnt_q == last_c) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wbit_q  <= 1'b0;
      rbit_q  <= 1'b0;
      pres_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wbit_q  <= wbit_d;
      rbit_q  <= rbit_d;
      pres_q  <= pres_d;
      done_q  <= done_d;
    end
  end

  // line drive: low phase at the head of every operation
  always_comb begin
    unique case (state_q)
      ST_RST:  line_oe = (cnt_q < C_RST_LOW);
      ST_WR:   line_oe = (cnt_q < (wbit_q ? C_W1 : C_W0));
      ST_RD:   line_oe = (cnt_q < C_RD_LOW);
      default: line_oe = 1'b0;
    endcase
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rd_bit   = rbit_q;
  assign presence = pres_q;

endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master #(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned RST_LOW_US = 480
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       wr_bit,
  input  logic       line_in,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       presence,
  output logic       line_oe
);

  localparam int unsigned DIV_RAW = CLK_HZ / 1_000_000;
  localparam int unsigned DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic [1:0] rs_q;
  logic       rst_sn;
  logic       tick;
  logic       line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sn = rs_q[1];

  sw_us_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_sn),
    .run  (busy),
    .tick (tick)
  );

  sw_line_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d    (line_in),
    .q    (line_s)
  );

  sw_slot_engine #(.RST_LOW_US(RST_LOW_US)) u_eng (
    .clk     (clk),
    .rst_n   (rst_sn),
    .tick    (tick),
    .start   (start),
    .op      (op),
    .wr_bit  (wr_bit),
    .line_s  (line_s),
    .busy    (busy),
    .done    (done),
    .rd_bit  (rd_bit),
    .presence(presence),
    .line_oe (line_oe)
  );

endmodule

// File: rtl/sw_bus_master_chk.sv
module sw_bus_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op,
  input logic       busy,
  input logic       done,
  input logic       rd_bit,
  input logic       presence,
  input logic       line_oe
);

  p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && ($past(op) != 2'd3)));

  p_slot_opens_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_oe);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_bit) |-> $past(busy));

  p_pres_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence) |-> ($past(busy) || $past(start)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind sw_bus_master sw_bus_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .op      (op),
  .busy    (busy),
  .done    (done),
  .rd_bit  (rd_bit),
  .presence(presence),
  .line_oe (line_oe)
);

// File: tb/test_sw_bus_master.sv
`timescale 1ns/1ps
module test_sw_bus_master;

  localparam int unsigned CLK_HZ = 4_000_000;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] op;
  logic       wr_bit;
  logic       line_in = 1'b1;
  logic       busy, done, rd_bit, presence, line_oe;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 0;

  // reference model state
  bit         m_busy = 0;
  bit         m_done = 0;
  int         m_n = 0;
  logic [1:0] m_op = 2'd0;
  logic       m_wb = 1'b0;

  // simulated device: 0 none, 1 presence pulse, 2 read-zero
  int sl_mode = 0;
  int sl_w = 0;
  int sl_l = 0;

  always #2.5 clk = ~clk;

  sw_bus_master #(.CLK_HZ(CLK_HZ)) i_sw_bus_master (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_bit(wr_bit),
    .line_in(line_in), .busy(busy), .done(done), .rd_bit(rd_bit),
    .presence(presence), .line_oe(line_oe)
  );

  function automatic int low_us();
    case (m_op)
      2'd0:    return 480;
      2'd1:    return m_wb ? 6 : 60;
      2'd2:    return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int end_us();
    return (m_op == 2'd0) ? 960 : 61;
  endfunction

  function automatic bit slave_low();
    if (!m_busy) return 0;
    if (sl_mode == 1 && m_op == 2'd0)
      return (m_n >= (480 + sl_w) * DIV) && (m_n < (480 + sl_w + sl_l) * DIV);
    if (sl_mode == 2 && m_op == 2'd2)
      return m_n < 30 * DIV;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_n = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_n++;
        if (m_n == end_us() * DIV) begin
          m_busy = 0;
          m_done = 1;
        end
      end else if (start && op != 2'd3) begin
        m_busy = 1; m_n = 0; m_op = op; m_wb = wr_bit;
      end
    end
  end

  // open-drain line with pull-up, updated away from the active edge
  always @(negedge clk) line_in <= !(line_oe || slave_low());

  // per-cycle comparison (R4 R5 R7 R9 R10 timing)
  always @(negedge clk) begin
    if (cmp_en) begin
      logic exp_oe;
      exp_oe = m_busy && (m_n < low_us() * DIV);
      checks++;
      if (busy !== m_busy || done !== m_done || line_oe !== exp_oe) begin
        fails++;
        $display("FAIL R10 R9 cycle n=%0d op=%0d: busy/done/oe=%b%b%b expected %b%b%b",
                 m_n, m_op, busy, done, line_oe, m_busy, m_done, exp_oe);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] o, logic wb, int mode, int w, int l,
                       logic exp_rd, logic exp_pres, string tag, bit intrude);
    int k;
    sl_mode = mode; sl_w = w; sl_l = l;
    @(negedge clk);
    start = 1'b1; op = o; wr_bit = wb;
    @(negedge clk);
    start = 1'b0; op = 2'd0; wr_bit = 1'b0;
    k = 0;
    while (!m_done && k < 20000) begin
      @(negedge clk);
      k++;
      if (intrude && k == 40) begin start = 1'b1; op = 2'd0; wr_bit = 1'b1; end
      if (intrude && k == 41) begin start = 1'b0; end
    end
    chk({tag, " done pulse"}, done, 1'b1);
    chk({tag, " rd_bit"}, rd_bit, exp_rd);
    chk({tag, " presence"}, presence, exp_pres);
    sl_mode = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'd0; wr_bit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 line_oe", line_oe, 0);
    chk("R1 rd_bit", rd_bit, 0);
    chk("R1 presence", presence, 0);
    cmp_en = 1;

    // R7 R8: presence window cases
    do_op(2'd0, 0, 1, 15, 60, 0, 1, "R7 R8 early presence", 0);
    do_op(2'd0, 0, 0, 0, 0, 0, 0, "R8 no device", 0);
    do_op(2'd0, 0, 1, 60, 240, 0, 1, "R8 slow long presence", 0);
    do_op(2'd0, 0, 1, 110, 60, 0, 1, "R8 inside late window", 0);
    do_op(2'd0, 0, 1, 130, 60, 0, 0, "R8 after window", 0);

    // R6 reads, R8 presence untouched by reads
    do_op(2'd2, 0, 2, 0, 0, 0, 0, "R6 read zero", 0);
    do_op(2'd0, 0, 1, 15, 60, 0, 1, "R7 reset again", 0);
    do_op(2'd2, 0, 0, 0, 0, 1, 1, "R6 R8 read one", 0);

    // R4 R5 writes leave results alone
    do_op(2'd1, 1, 0, 0, 0, 1, 1, "R4 R6 write one", 0);
    do_op(2'd1, 0, 0, 0, 0, 1, 1, "R5 R6 write zero", 0);
    do_op(2'd2, 0, 2, 0, 0, 0, 1, "R6 read zero again", 0);

    // R3: reset request during a write0 slot is ignored
    do_op(2'd1, 0, 0, 0, 0, 0, 1, "R3 start while busy", 1);

    // R2: reserved code 3 is not accepted
    @(negedge clk);
    start = 1'b1; op = 2'd3;
    @(negedge clk);
    start = 1'b0; op = 2'd0;
    chk("R2 code3 busy", busy, 0);
    chk("R2 code3 line_oe", line_oe, 0);
    repeat (3) @(negedge clk);
    chk("R2 code3 busy later", busy, 0);

    // R2: accepted code raises busy in the next cycle
    @(negedge clk);
    start = 1'b1; op = 2'd2;
    @(negedge clk);
    start = 1'b0;
    chk("R2 read accepted busy", busy, 1);
    chk("R2 read accepted line_oe", line_oe, 1);
    while (!m_done) @(negedge clk);
    chk("R6 R9 read done", done, 1);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);

    cmp_en = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule